// File: doc/BRIEF.md
# Prioritized Interrupt Index Controller

This block collects nine single-cycle event pulses from a serial peripheral into sticky raw flags. A mask register selects which flags may raise the interrupt line. A fixed-priority encoder reports the most urgent pending unmasked event as a small index number. Software can force flags on or off through write-one-to-act registers, and can also read the raw, mask and masked views.

Reading the index register acknowledges the event it reports. That read clears the event's raw flag, so the next read returns the next event in priority order. A read marked as debug traffic shows the same index but leaves every flag untouched.

The register port takes one request per cycle. A read returns its data, with a valid strobe, in the cycle after the request. A small two-state machine runs the read response: `PORT_IDLE` has no response pending, and `PORT_RESP` presents read data. The transition `PORT_IDLE` to `PORT_RESP` is taken on any read request. `PORT_RESP` stays in `PORT_RESP` on a back-to-back read. `PORT_RESP` returns to `PORT_IDLE` when there is no read.

Top module: `intr_index_ctrl`

## Requirements
- R1: After reset the raw flags and mask are all zero, `irq_o` is low and `rvalid_o` is low.
- R2: A high `evt_i` bit sets the matching raw flag at the next clock edge. The flag stays set until software clears it or an index read acknowledges it.
- R3: The masked view is the raw flags ANDed with the mask (mask bit 1 means enabled). `irq_o` is high exactly when any masked bit is set.
- R4: The index reads 0 when no masked bit is set. Otherwise it reads one more than the position of the lowest set masked bit, so bit 0 gives index 1 and has the highest priority.
- R5: A non-debug read of the index register clears the raw flag it reports. A following read returns the next pending index, or 0 when none remains.
- R6: A read with `dbg_i` high changes no flag, whatever address it targets.
- R7: Writing the set register (address 4) sets each raw flag whose data bit is 1. Bits written as 0 have no effect.
- R8: Writing the clear register (address 5) clears each raw flag whose data bit is 1, masked or not. Bits written as 0 have no effect.
- R9: When a hardware event pulse and a clear, whether from the clear register or from an index read, hit the same flag in the same cycle, the flag ends up set.
- R10: The address map is: 0 index, 1 mask, 2 raw, 3 masked, 4 set, 5 clear. A read returns `rvalid_o` high one cycle after the request, with the register value as it was at the request. Addresses 4 to 7 read as 0. A write never produces `rvalid_o`.
- R11: Writes to the index, raw and masked addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| req_i | input | 1 | Register access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | NUM_SRC | Write data |
| dbg_i | input | 1 | Marks the access as debug traffic |
| rdata_o | output | NUM_SRC | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a flag receiving a set and a clear in the very same cycle. The clear may come from the clear register or from the acknowledge side effect of an index read. Either way it must lose to the hardware pulse. The stimulus lines an event pulse up on the same falling edge as a clear-register write, and on the same edge as a non-debug index read whose reported bit is the one being pulsed. It then reads the raw view to see that the flag survived. The index walk also mixes debug and normal reads over several pending events, which shows that only normal reads advance the priority sequence.

// File: rtl/intr_idx_pkg.sv
package intr_idx_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_INDEX  = 3'd0,
        A_MASK   = 3'd1,
        A_RAW    = 3'd2,
        A_MASKED = 3'd3,
        A_SET    = 3'd4,
        A_CLR    = 3'd5
    } reg_addr_e;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;
endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i + 1);
        end
    end
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set_i,
    input  logic [N-1:0] sw_set_i,
    input  logic [N-1:0] sw_clr_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // A set in the same cycle as a clear takes precedence.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_o[g] <= 1'b0;
            end else if (hw_set_i[g] || sw_set_i[g]) begin
                flags_o[g] <= 1'b1;
            end else if (sw_clr_i[g] || ack_clr_i[g]) begin
                flags_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/intr_regport.sv
module intr_regport
    import intr_idx_pkg::*;
#(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic              dbg_i,
    input  logic [N-1:0]      raw_i,
    input  logic [N-1:0]      masked_i,
    input  logic [IW-1:0]     idx_i,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      sw_set_o,
    output logic [N-1:0]      sw_clr_o,
    output logic [N-1:0]      ack_clr_o,
    output logic [N-1:0]      rdata_o,
    output logic              rvalid_o
);
    port_state_e state_q, state_d;
    logic        rd_req, wr_req;
    reg_addr_e   sel;
    logic [N-1:0] rd_mux;
    logic [N-1:0] lowest;

    assign rd_req = req_i && !wr_i;
    assign wr_req = req_i && wr_i;
    assign sel    = reg_addr_e'(addr_i);
    // Isolate the lowest set masked bit: that is the event being acknowledged.
    assign lowest = masked_i & (~masked_i + N'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_req)  state_d = PORT_RESP;
            PORT_RESP: if (!rd_req) state_d = PORT_IDLE;
            default:                state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (sel)
            A_INDEX:  rd_mux = N'(idx_i);
            A_MASK:   rd_mux = mask_o;
            A_RAW:    rd_mux = raw_i;
            A_MASKED: rd_mux = masked_i;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
            mask_o  <= '0;
        end else begin
            if (rd_req) rdata_o <= rd_mux;
            if (wr_req && sel == A_MASK) mask_o <= wdata_i;
        end
    end

    always_comb begin
        rvalid_o  = (state_q == PORT_RESP);
        sw_set_o  = (wr_req && sel == A_SET) ? wdata_i : '0;
        sw_clr_o  = (wr_req && sel == A_CLR) ? wdata_i : '0;
        ack_clr_o = (rd_req && sel == A_INDEX && !dbg_i) ? lowest : '0;
    end
endmodule

// File: rtl/intr_index_ctrl.sv
module intr_index_ctrl
    import intr_idx_pkg::*;
#(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               req_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic               dbg_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               rvalid_o,
    output logic               irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] raw_q, mask_q, masked;
    logic [NUM_SRC-1:0] sw_set, sw_clr, ack_clr;
    logic [IDX_W-1:0]   idx;

    assign masked = raw_q & mask_q;
    assign irq_o  = |masked;

    intr_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set_i  (evt_i),
        .sw_set_i  (sw_set),
        .sw_clr_i  (sw_clr),
        .ack_clr_i (ack_clr),
        .flags_o   (raw_q)
    );

    intr_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
        .vec_i (masked),
        .idx_o (idx)
    );

    intr_regport #(.N(NUM_SRC), .IW(IDX_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .dbg_i     (dbg_i),
        .raw_i     (raw_q),
        .masked_i  (masked),
        .idx_i     (idx),
        .mask_o    (mask_q),
        .sw_set_o  (sw_set),
        .sw_clr_o  (sw_clr),
        .ack_clr_o (ack_clr),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );
endmodule

// File: rtl/intr_index_ctrl_chk.sv
module intr_index_ctrl_chk #(
    parameter int NUM_SRC = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               req_i,
    input logic               wr_i,
    input logic [2:0]         addr_i,
    input logic               dbg_i,
    input logic [NUM_SRC-1:0] rdata_o,
    input logic               rvalid_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] raw_q
);
    // R10: each read is answered in the following cycle
    p_read_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i) |=> rvalid_o);

    // R10: no response without a read the cycle before
    p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !wr_i) |=> !rvalid_o);

    // R4: the index never exceeds the number of sources
    p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i && addr_i == 3'd0) |=> (rdata_o <= NUM_SRC));

    // R2: a pulsed source has its flag set one edge later
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    // R6: a debug read drops no flag
    p_debug_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i && dbg_i) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R3: a nonzero masked view coincides with the interrupt line
    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i && addr_i == 3'd3) |=> ((rdata_o != '0) == $past(irq_o)));
endmodule

bind intr_index_ctrl intr_index_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .dbg_i    (dbg_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .irq_o    (irq_o),
    .raw_q    (raw_q)
);

// File: tb/intr_index_ctrl_bench.sv
module intr_index_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         req_i = 1'b0;
    logic         wr_i = 1'b0;
    logic [2:0]   addr_i = '0;
    logic [N-1:0] wdata_i = '0;
    logic         dbg_i = 1'b0;
    logic [N-1:0] rdata_o;
    logic         rvalid_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic [N-1:0] m_raw = '0;
    logic [N-1:0] m_mask = '0;

    intr_index_ctrl #(.NUM_SRC(N)) u_intr_index_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .req_i(req_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .dbg_i(dbg_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] prio(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(i + 1);
        return '0;
    endfunction

    // Scoreboard monitor: every response is matched against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rvalid_o) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected response", 32'(rvalid_o), 32'd0);
                end else begin
                    check(tag_q.pop_front(), 32'(rdata_o), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    // Driver: read with optional same-cycle event pulse.
    task automatic rd(logic [2:0] a, logic dbg, string tag, logic [N-1:0] ev = '0);
        logic [N-1:0] e;
        logic [N-1:0] ix;
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b0; addr_i = a; dbg_i = dbg; evt_i = ev;
        ix = prio(m_raw & m_mask);
        case (a)
            3'd0: e = ix;
            3'd1: e = m_mask;
            3'd2: e = m_raw;
            3'd3: e = m_raw & m_mask;
            default: e = '0;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (a == 3'd0 && !dbg && ix != 0) m_raw[ix - 1] = 1'b0;
        m_raw |= ev;
        @(negedge clk);
        req_i = 1'b0; dbg_i = 1'b0; evt_i = '0;
    endtask

    // Driver: write with optional same-cycle event pulse.
    task automatic wr(logic [2:0] a, logic [N-1:0] d, logic [N-1:0] ev = '0);
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d; evt_i = ev;
        case (a)
            3'd1: m_mask = d;
            3'd4: m_raw |= d;
            3'd5: m_raw &= ~d;
            default: ;
        endcase
        m_raw |= ev;
        @(negedge clk);
        req_i = 1'b0; wr_i = 1'b0; evt_i = '0;
    endtask

    task automatic pulse(logic [N-1:0] ev);
        @(negedge clk);
        evt_i = ev;
        m_raw |= ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic chk_irq(string tag);
        @(negedge clk);
        check(tag, 32'(irq_o), 32'(|(m_raw & m_mask)));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rvalid", 32'(rvalid_o), 32'd0);
        chk_irq("R1 irq");
        rd(3'd2, 1'b0, "R1 raw");
        rd(3'd1, 1'b0, "R1 mask");
        rd(3'd0, 1'b0, "R1 index");
        // R2 sticky flag
        pulse(9'h008);
        rd(3'd2, 1'b0, "R2 raw after pulse");
        repeat (5) @(negedge clk);
        rd(3'd2, 1'b0, "R2 raw sticky");
        // R3/R4 masked off
        chk_irq("R3 irq masked off");
        rd(3'd3, 1'b0, "R3 masked off");
        rd(3'd0, 1'b0, "R4 index none");
        wr(3'd1, 9'h1FF);
        chk_irq("R3 irq enabled");
        rd(3'd3, 1'b0, "R3 masked on");
        // R4/R5/R6 priority walk
        pulse(9'h124);
        rd(3'd0, 1'b0, "R4 index bit2");
        rd(3'd0, 1'b0, "R5 index bit3");
        rd(3'd0, 1'b1, "R6 debug index");
        rd(3'd0, 1'b1, "R6 debug index again");
        rd(3'd2, 1'b1, "R6 raw after debug");
        rd(3'd0, 1'b0, "R5 index bit5");
        rd(3'd0, 1'b0, "R5 index bit8");
        rd(3'd0, 1'b0, "R5 index empty");
        chk_irq("R5 irq dropped");
        // R7 set register
        wr(3'd1, 9'h0F0);
        wr(3'd4, 9'h0A0);
        rd(3'd2, 1'b0, "R7 raw after set");
        wr(3'd4, 9'h000);
        rd(3'd2, 1'b0, "R7 zero set");
        rd(3'd3, 1'b0, "R3 partial mask");
        rd(3'd0, 1'b1, "R4 index partial mask");
        // R8 clear register on a masked-off flag
        wr(3'd4, 9'h001);
        rd(3'd2, 1'b0, "R7 set masked-off bit");
        wr(3'd5, 9'h001);
        rd(3'd2, 1'b0, "R8 clear masked-off bit");
        wr(3'd5, 9'h000);
        rd(3'd2, 1'b0, "R8 zero clear");
        // R9 set beats clear
        wr(3'd5, 9'h0A0, 9'h020);
        rd(3'd2, 1'b0, "R9 clear vs event");
        rd(3'd0, 1'b0, "R9 index read vs event", 9'h020);
        rd(3'd2, 1'b0, "R9 ack vs event");
        // R11 read-only writes
        wr(3'd2, 9'h1FF);
        wr(3'd3, 9'h1FF);
        wr(3'd0, 9'h1FF);
        rd(3'd2, 1'b0, "R11 raw unchanged");
        rd(3'd1, 1'b0, "R11 mask unchanged");
        // R10 unused addresses
        rd(3'd6, 1'b0, "R10 addr6");
        rd(3'd4, 1'b0, "R10 set addr reads 0");
        chk_irq("R3 irq final");
        repeat (3) @(negedge clk);
        check("R10 queue drained", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule